// File: doc/BRIEF.md
# Timer counter with output compare

This block is an 8-bit timer whose count moves one step on each qualified timer tick, and which has a single output compare channel. A tick counts only when the clock-source selector is non-zero and the tick strobe is high, so a selector of zero freezes the whole unit. A small write port reaches four registers: control (mode and interrupt enables), the count itself, the compare value, and a write-one-to-clear flag register. Ticks come from an external prescaler. That prescaler, any asynchronous oscillator and the bus decode sit outside this block.

Four modes are available. Two of them are plain: free-running wrap and clear-on-match. In both, the compare value takes effect one cycle after it is written, and the waveform pin toggles on every match. The other two are PWM modes: single-slope and dual-slope. In these, a written compare value waits in a holding register and moves into the active comparator only on a tick at the count 0xFF, so a period is never cut short. The dual-slope mode counts up to 0xFF and back down to 0x00. A compare match sets a sticky flag, and so does the overflow point of the current mode. Each flag drives an interrupt request through its own enable bit.

Top module: `timer_ocmp`

## Requirements
- R1: While `src_sel` is 0 or `tick` is low, the count, the waveform output and both flags keep their values.
- R2: In mode 0 (free-running), each tick adds one to the count, and 0xFF wraps to 0x00. A tick taken at count 0xFF sets the overflow flag.
- R3: In mode 2 (clear-on-match), a tick taken when the count equals the active compare value returns the count to 0x00. In modes 0 and 2, every such matching tick inverts `wave_out`. In mode 2, the overflow flag is set by a tick at 0xFF.
- R4: In mode 3 (single-slope PWM), the count wraps at 0xFF. A matching tick drives `wave_out` low. Otherwise, a tick at 0x00 drives it high. A tick at 0xFF sets the overflow flag.
- R5: In mode 1 (dual-slope PWM), the count rises from 0x00 to 0xFF and then falls back to 0x00. A tick at 0x00 sets the overflow flag. A matching tick on the rising side drives `wave_out` low, and one on the falling side drives it high. The tick at 0x00 belongs to the rising side and the tick at 0xFF belongs to the falling side.
- R6: A write to register 2 (compare) takes effect on the next cycle in modes 0 and 2. In modes 1 and 3, the value is held and becomes active only after a tick at count 0xFF.
- R7: `cmp_flag` is set by any tick taken when the count equals the active compare value, and it stays set until software clears it.
- R8: A write to register 3 clears `cmp_flag` when data bit 0 is 1 and clears `ovf_flag` when data bit 1 is 1. Zero bits leave a flag unchanged. A set in the same cycle beats the clear.
- R9: `cmp_irq` equals `cmp_flag` AND control bit 2. `ovf_irq` equals `ovf_flag` AND control bit 3. Control bits [1:0] hold the mode.
- R10: A write to register 1 loads the count. It cancels every tick action in that cycle: count step, flags, waveform and compare hand-over.
- R11: Synchronous reset clears the count, the compare value, the control register, both flags and `wave_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Clock-source selector; 0 means no source |
| tick | input | 1 | Timer tick strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 count, 2 compare, 3 flag clear |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current count |
| wave_out | output | 1 | Compare waveform output |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A hardware flag set and a software clear of the same flag can land in the same cycle, and the set must win. The bench forces this case directly: it loads the count with 0xFF and then ticks while writing a clear of the overflow flag. Random traffic also sends flag-clear writes while the count passes through matches. A cycle-level reference model predicts the flag after every cycle, and a clear that wins is reported at once. The same model covers a second collision: in single-slope PWM with a compare value of 0x00, the tick at count 0x00 is also a match, and the output must stay low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_DUAL     = 2'd1,
        MODE_CLRMATCH = 2'd2,
        MODE_SINGLE   = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_COUNT   = 2'd1,
        REG_CMP     = 2'd2,
        REG_FLAGCLR = 2'd3
    } tmr_reg_e;

    localparam int CTRL_W = 4;

    typedef struct packed {
        logic      ovf_ie;
        logic      cmp_ie;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    typedef struct packed {
        logic adv;
        logic match;
        logic at_max;
        logic at_bottom;
        logic slope_dn;
    } tmr_evt_t;

    function automatic logic is_pwm(tmr_mode_e m);
        return (m == MODE_DUAL) || (m == MODE_SINGLE);
    endfunction

    function automatic tmr_ctrl_t decode_ctrl(logic [CTRL_W-1:0] d);
        return tmr_ctrl_t'(d);
    endfunction

endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    input  tmr_mode_e     mode,
    input  logic [W-1:0]  top_cmp,
    output logic [W-1:0]  cnt,
    output logic          at_max,
    output logic          at_bottom,
    output logic          slope_dn
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] BOTV = '0;

    logic [W-1:0] cnt_q, cnt_d;
    logic         dir_q, dir_d;

    assign at_max    = (cnt_q == MAXV);
    assign at_bottom = (cnt_q == BOTV);

    // The tick at the top belongs to the falling slope, the tick at the bottom to the rising one.
    always_comb begin
        slope_dn = 1'b0;
        if (mode == MODE_DUAL) begin
            if (at_max)
                slope_dn = 1'b1;
            else if (at_bottom)
                slope_dn = 1'b0;
            else
                slope_dn = dir_q;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d = ld_val;
        end else if (adv) begin
            case (mode)
                MODE_CLRMATCH: cnt_d = (cnt_q == top_cmp) ? BOTV : cnt_q + 1'b1;
                MODE_DUAL:     cnt_d = slope_dn ? cnt_q - 1'b1 : cnt_q + 1'b1;
                default:       cnt_d = cnt_q + 1'b1;
            endcase
        end
    end

    always_comb begin
        dir_d = dir_q;
        if (mode != MODE_DUAL)
            dir_d = 1'b0;
        else if (adv)
            dir_d = slope_dn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= BOTV;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt = cnt_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv && !ld) |=> $stable(cnt)); // R1
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_FREE) |=> (cnt == W'($past(cnt) + 1'b1))); // R2
    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_CLRMATCH && cnt == top_cmp) |=> (cnt == BOTV)); // R3
    AST_DUAL_TURN: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_DUAL && at_max) |=> (cnt == MAXV - 1'b1)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val))); // R10

endmodule

// File: rtl/tmr_cmp_buffer.sv
module tmr_cmp_buffer #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wr_val,
    input  logic          pwm,
    input  logic          swap,
    output logic [W-1:0]  act
);

    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr)
                hold_q <= wr_val;
            if (wr && !pwm)
                act_q <= wr_val;
            else if (pwm && swap)
                act_q <= hold_q;
        end
    end

    assign act = act_q;

    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwm && !swap) |=> $stable(act)); // R6
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && !pwm) |=> (act == $past(wr_val))); // R6

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_evt_t  evt,
    input  tmr_mode_e mode,
    output logic      wave
);

    logic wave_q, wave_d;

    always_comb begin
        wave_d = wave_q;
        if (evt.adv) begin
            case (mode)
                MODE_SINGLE: begin
                    if (evt.match)
                        wave_d = 1'b0;
                    else if (evt.at_bottom)
                        wave_d = 1'b1;
                end
                MODE_DUAL: begin
                    if (evt.match)
                        wave_d = evt.slope_dn;
                end
                default: begin
                    if (evt.match)
                        wave_d = ~wave_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            wave_q <= 1'b0;
        else
            wave_q <= wave_d;
    end

    assign wave = wave_q;

    AST_WAVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !evt.adv |=> $stable(wave)); // R1
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (evt.adv && evt.match && !is_pwm(mode)) |=> (wave != $past(wave))); // R3
    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt.adv && evt.match && mode == MODE_SINGLE) |=> !wave); // R4
    AST_DUAL_FALL_SET: assert property (@(posedge clk) disable iff (rst)
        (evt.adv && evt.match && mode == MODE_DUAL && evt.at_max) |=> wave); // R5

endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
    parameter int N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  set,
    input  logic [N-1:0]  clr,
    input  logic [N-1:0]  en,
    output logic [N-1:0]  flag,
    output logic [N-1:0]  irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;

        always_ff @(posedge clk) begin
            if (rst)
                f_q <= 1'b0;
            else if (set[i])
                f_q <= 1'b1;
            else if (clr[i])
                f_q <= 1'b0;
        end

        assign flag[i] = f_q;
        assign irq[i]  = f_q & en[i];

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flag[i]); // R8
        AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !flag[i]); // R8
        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !clr[i]) |=> flag[i]); // R7
    end

endmodule

// File: rtl/timer_ocmp.sv
module timer_ocmp
    import tmr_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     count,
    output logic             wave_out,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             cmp_irq,
    output logic             ovf_irq
);

    localparam int FLAG_N  = 2;
    localparam int F_CMP   = 0;
    localparam int F_OVF   = 1;

    tmr_ctrl_t     ctrl_q;
    tmr_evt_t      evt;
    logic          pwm;
    logic          wr_ctrl, wr_cnt, wr_cmp, wr_clr;
    logic [W-1:0]  cmp_act;
    logic [W-1:0]  cnt;
    logic          at_max, at_bottom, slope_dn;
    logic          ovf_point;
    logic [FLAG_N-1:0] f_set, f_clr, f_en, f_val, f_irq;
    logic          unused_data;

    assign unused_data = ^wr_data[W-1:CTRL_W];

    // Register decode
    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    assign wr_cnt  = wr_en && (wr_addr == REG_COUNT);
    assign wr_cmp  = wr_en && (wr_addr == REG_CMP);
    assign wr_clr  = wr_en && (wr_addr == REG_FLAGCLR);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= decode_ctrl(wr_data[CTRL_W-1:0]);
    end

    assign pwm = is_pwm(ctrl_q.mode);

    // A tick counts only with a source selected and no count write pending
    always_comb begin
        evt.adv       = (src_sel != '0) && tick && !wr_cnt;
        evt.match     = (cnt == cmp_act);
        evt.at_max    = at_max;
        evt.at_bottom = at_bottom;
        evt.slope_dn  = slope_dn;
    end

    assign ovf_point = (ctrl_q.mode == MODE_DUAL) ? at_bottom : at_max;

    tmr_count_unit #(.W(W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .adv       (evt.adv),
        .ld        (wr_cnt),
        .ld_val    (wr_data),
        .mode      (ctrl_q.mode),
        .top_cmp   (cmp_act),
        .cnt       (cnt),
        .at_max    (at_max),
        .at_bottom (at_bottom),
        .slope_dn  (slope_dn)
    );

    tmr_cmp_buffer #(.W(W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_cmp),
        .wr_val (wr_data),
        .pwm    (pwm),
        .swap   (evt.adv && at_max),
        .act    (cmp_act)
    );

    tmr_wavegen u_wave (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .mode (ctrl_q.mode),
        .wave (wave_out)
    );

    assign f_set[F_CMP] = evt.adv && evt.match;
    assign f_set[F_OVF] = evt.adv && ovf_point;
    assign f_clr[F_CMP] = wr_clr && wr_data[0];
    assign f_clr[F_OVF] = wr_clr && wr_data[1];
    assign f_en[F_CMP]  = ctrl_q.cmp_ie;
    assign f_en[F_OVF]  = ctrl_q.ovf_ie;

    tmr_flag_unit #(.N(FLAG_N)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (f_set),
        .clr  (f_clr),
        .en   (f_en),
        .flag (f_val),
        .irq  (f_irq)
    );

    assign count    = cnt;
    assign cmp_flag = f_val[F_CMP];
    assign ovf_flag = f_val[F_OVF];
    assign cmp_irq  = f_irq[F_CMP];
    assign ovf_irq  = f_irq[F_OVF];

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (src_sel == '0 && !wr_en) |=> ($stable(count) && $stable(cmp_flag) && $stable(ovf_flag))); // R1
    AST_DUAL_OVF: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_DUAL && src_sel != '0 && tick && !wr_en && count == '0) |=> ovf_flag); // R5

endmodule

// File: tb/timer_ocmp_test.sv
`timescale 1ns/1ps
module timer_ocmp_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] src_sel;
    logic       tick, wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] count;
    logic       wave_out, cmp_flag, ovf_flag, cmp_irq, ovf_irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // reference state
    logic [7:0] m_cnt, m_act, m_hold;
    logic [1:0] m_mode;
    logic       m_dir, m_cie, m_oie, m_cf, m_of, m_wave;

    always #4 clk = ~clk;

    timer_ocmp uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .wave_out(wave_out), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 8'h00; m_act = 8'h00; m_hold = 8'h00; m_mode = 2'd0;
        m_dir = 1'b0; m_cie = 1'b0; m_oie = 1'b0; m_cf = 1'b0; m_of = 1'b0; m_wave = 1'b0;
    endtask

    function automatic bit pwm_mode(logic [1:0] m);
        return (m == 2'd1) || (m == 2'd3);
    endfunction

    task automatic model_step(logic [2:0] s, logic t, logic w, logic [1:0] a, logic [7:0] d);
        bit adv, match, top, bot, dn, ovf_ev;
        logic [7:0] n_cnt, n_act;
        logic n_dir, n_wave;
        adv   = (s != 3'd0) && t && !(w && a == 2'd1);
        match = (m_cnt == m_act);
        top   = (m_cnt == 8'hFF);
        bot   = (m_cnt == 8'h00);
        dn    = (m_mode == 2'd1) && (top ? 1'b1 : (bot ? 1'b0 : m_dir));
        n_cnt = m_cnt; n_dir = m_dir; n_wave = m_wave; n_act = m_act;
        if (w && a == 2'd1) n_cnt = d;
        else if (adv) begin
            if (m_mode == 2'd2)      n_cnt = match ? 8'h00 : m_cnt + 8'd1;
            else if (m_mode == 2'd1) n_cnt = dn ? m_cnt - 8'd1 : m_cnt + 8'd1;
            else                     n_cnt = m_cnt + 8'd1;
        end
        if (m_mode != 2'd1) n_dir = 1'b0;
        else if (adv)       n_dir = dn;
        if (adv) begin
            if (m_mode == 2'd3) begin
                if (match) n_wave = 1'b0;
                else if (bot) n_wave = 1'b1;
            end else if (m_mode == 2'd1) begin
                if (match) n_wave = dn;
            end else if (match) n_wave = ~m_wave;
        end
        ovf_ev = adv && ((m_mode == 2'd1) ? bot : top);
        if (w && a == 2'd2 && !pwm_mode(m_mode)) n_act = d;
        else if (pwm_mode(m_mode) && adv && top) n_act = m_hold;
        if (w && a == 2'd2) m_hold = d;
        m_cf = (adv && match) | (m_cf & !(w && a == 2'd3 && d[0]));
        m_of = ovf_ev        | (m_of & !(w && a == 2'd3 && d[1]));
        if (w && a == 2'd0) begin
            m_mode = d[1:0]; m_cie = d[2]; m_oie = d[3];
        end
        m_cnt = n_cnt; m_dir = n_dir; m_wave = n_wave; m_act = n_act;
    endtask

    task automatic compare_all(string req);
        chk(req, "count", {24'd0, count}, {24'd0, m_cnt});
        chk(req, "wave_out", {31'd0, wave_out}, {31'd0, m_wave});
        chk("R7", "cmp_flag", {31'd0, cmp_flag}, {31'd0, m_cf});
        chk(req, "ovf_flag", {31'd0, ovf_flag}, {31'd0, m_of});
        chk("R9", "cmp_irq", {31'd0, cmp_irq}, {31'd0, m_cf & m_cie});
        chk("R9", "ovf_irq", {31'd0, ovf_irq}, {31'd0, m_of & m_oie});
    endtask

    task automatic step(string req, logic [2:0] s, logic t, logic w, logic [1:0] a, logic [7:0] d);
        src_sel = s; tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(s, t, w, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all(req);
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) step(req, 3'd1, 1'b1, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wreg(string req, logic [1:0] a, logic [7:0] d);
        step(req, 3'd1, 1'b0, 1'b1, a, d);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; src_sel = 3'd0; tick = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R11");
        rst = 1'b0;

        // R1: no source, or no tick
        for (int i = 0; i < 5; i++) step("R1", 3'd0, 1'b1, 1'b0, 2'd0, 8'h00);
        for (int i = 0; i < 5; i++) step("R1", 3'd5, 1'b0, 1'b0, 2'd0, 8'h00);
        chk("R1", "count held", {24'd0, count}, 32'd0);

        // R2: free-running wrap and overflow
        wreg("R10", 2'd1, 8'hFC);
        chk("R10", "count loaded", {24'd0, count}, 32'h0FC);
        run("R2", 6);
        chk("R2", "count after wrap", {24'd0, count}, 32'h002);
        chk("R2", "overflow set", {31'd0, ovf_flag}, 32'd1);

        // R8: clearing and set-beats-clear
        wreg("R8", 2'd3, 8'h03);
        chk("R8", "flags cleared", {30'd0, cmp_flag, ovf_flag}, 32'd0);
        wreg("R10", 2'd1, 8'hFF);
        step("R8", 3'd1, 1'b1, 1'b1, 2'd3, 8'h02);
        chk("R8", "set beats clear", {31'd0, ovf_flag}, 32'd1);
        wreg("R8", 2'd3, 8'h00);
        chk("R8", "zero write keeps flag", {31'd0, ovf_flag}, 32'd1);

        // R9: interrupt enables
        wreg("R9", 2'd0, 8'h0C);
        chk("R9", "ovf_irq enabled", {31'd0, ovf_irq}, 32'd1);
        wreg("R9", 2'd0, 8'h00);
        chk("R9", "ovf_irq masked", {31'd0, ovf_irq}, 32'd0);

        // R3 / R6: clear-on-match, direct compare load
        wreg("R6", 2'd2, 8'h05);
        wreg("R3", 2'd0, 8'h02);
        wreg("R10", 2'd1, 8'h00);
        run("R3", 20);
        wreg("R10", 2'd1, 8'hF0);
        run("R3", 30);

        // R10: count write beats a tick
        step("R10", 3'd1, 1'b1, 1'b1, 2'd1, 8'h40);
        chk("R10", "write wins over tick", {24'd0, count}, 32'h040);

        // R4 / R6: single-slope PWM with buffered compare
        wreg("R4", 2'd0, 8'h03);
        wreg("R6", 2'd2, 8'h80);
        run("R4", 300);
        wreg("R6", 2'd2, 8'h10);
        run("R6", 300);
        wreg("R4", 2'd2, 8'h00);
        run("R4", 520);
        wreg("R4", 2'd2, 8'hFF);
        run("R4", 520);

        // R5: dual-slope PWM
        wreg("R5", 2'd0, 8'h01);
        wreg("R5", 2'd2, 8'h40);
        wreg("R10", 2'd1, 8'h00);
        run("R5", 600);
        wreg("R5", 2'd2, 8'hFF);
        run("R5", 520);
        wreg("R5", 2'd2, 8'h00);
        run("R5", 520);

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [2:0] s;
            logic t, w;
            logic [1:0] a;
            logic [7:0] d;
            s = ($urandom_range(0, 9) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
            t = ($urandom_range(0, 9) < 8);
            w = ($urandom_range(0, 19) == 0);
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom_range(0, 255));
            if (a == 2'd0) d = {4'h0, d[3:0]};
            step("R7", s, t, w, a, d);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule